// File: doc/BRIEF.md
# Byte-Serial MOV Instruction Decoder

This block takes a stream of instruction bytes, one per handshake, and decodes a small group of 16-bit real-mode move instructions. Three forms are supported: the register/memory move between a general register and a register-or-memory operand, the store of an immediate into a register-or-memory operand, and the move between a segment register and a register-or-memory operand. The decoder does not know an instruction's length when it sees the opcode. It works out the length byte by byte, from the addressing-mode field, the direct-address special case and, for immediate stores, the operand width.

When the last byte of an instruction arrives, the decoder presents one record. The record gives the operation kind, direction, width, addressing mode, register selector, operand selector, displacement, immediate and total byte length. The record is held until the consumer accepts it, and the next opcode byte can enter in the same cycle. Address generation, memory access and execution belong to later stages. An opcode that is not supported produces a one-byte record flagged illegal.

Top module: `movdec`

## Requirements
- R1: After synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Opcodes 88h–8Bh decode as kind 0 (register/memory move), with `out_dir` = opcode bit 1 and `out_wide` = opcode bit 0. The second byte supplies `out_mode` (bits 7:6), `out_reg` (bits 5:3) and `out_rm` (bits 2:0). With mode 11 the length is 2. The displacement and immediate fields read zero when no bytes were collected for them.
- R3: Mode 01 takes exactly one displacement byte, sign-extended to 16 bits.
- R4: Mode 10 takes two displacement bytes, low byte first.
- R5: Mode 00 with operand selector 110 takes a 16-bit direct displacement, low byte first. Mode 00 with any other selector takes no displacement.
- R6: Opcodes C6h/C7h decode as kind 1 with `out_dir` = 0. The immediate follows any displacement, low byte first. It is one byte when opcode bit 0 is 0 and two bytes when that bit is 1, so the length reaches at most 6.
- R7: Opcodes 8Ch (to register/memory, `out_dir` = 0) and 8Eh (into segment register, `out_dir` = 1) decode as kind 2 with `out_wide` = 1. Segment selector codes 0–5 are legal when `SEG_EXT` = 1, codes 4–5 are illegal when `SEG_EXT` = 0, and codes 6–7 are always illegal.
- R8: Opcode 8Eh with segment selector 001 (a write to the code segment) sets `out_illegal`, after the full instruction has been collected.
- R9: Any other opcode gives a record with kind 3, `out_illegal` = 1, length 1 and all other fields zero, and the decoder then waits for a new opcode.
- R10: While `out_valid` is 1 and `out_ready` is 0, the record stays unchanged and `in_ready` is 0, so no byte is consumed.
- R11: In a cycle where the record is accepted, `in_ready` is 1, so the next opcode byte enters in that same cycle.
- R12: Reset in the middle of an instruction discards the collected bytes. The next byte is treated as an opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_data | input | 8 | Instruction byte |
| in_ready | output | 1 | Byte is taken when valid and ready are both 1 |
| out_valid | output | 1 | Decoded record present |
| out_ready | input | 1 | Consumer accepts the record |
| out_illegal | output | 1 | Instruction is not supported or not permitted |
| out_kind | output | 2 | 0 reg/mem move, 1 immediate store, 2 segment move, 3 unknown |
| out_dir | output | 1 | 1: data flows into the register named by `out_reg` |
| out_wide | output | 1 | 1: word operand, 0: byte operand |
| out_mode | output | 2 | Addressing-mode field |
| out_reg | output | 3 | Register or segment selector |
| out_rm | output | 3 | Register/memory operand selector |
| out_disp | output | 16 | Displacement, sign-extended when one byte |
| out_imm | output | 16 | Immediate, zero-extended when one byte |
| out_len | output | 3 | Total instruction length in bytes |

## Verification
The bench builds the decoder with the default `SEG_EXT` = 1. That setting puts the legal FS/GS selector codes within reach, next to the always-illegal codes 6 and 7 and the forbidden code-segment write. Every length from 1 to 6 is produced, including the sign extension of a negative one-byte displacement. Back-to-back instructions make the overlap of record acceptance and opcode intake happen repeatedly. A stalled consumer, with an opcode waiting at the input, and a reset in the middle of an instruction are both exercised.

// File: rtl/movdec_pkg.sv
package movdec_pkg;

    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int MAX_LEN = 6;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    typedef enum logic [1:0] {
        K_RM  = 2'd0,
        K_IMM = 2'd1,
        K_SEG = 2'd2,
        K_BAD = 2'd3
    } mov_kind_e;

    typedef enum logic [2:0] {
        ST_OPC, ST_MRM, ST_DLO, ST_DHI, ST_ILO, ST_IHI, ST_HOLD
    } dec_state_e;

    typedef struct packed {
        logic              illegal;
        mov_kind_e         kind;
        logic              dir;
        logic              wide;
        logic [1:0]        mode;
        logic [2:0]        rsel;
        logic [2:0]        rmsel;
        logic [WORD_W-1:0] disp;
        logic [WORD_W-1:0] imm;
        logic [LEN_W-1:0]  len;
    } mov_rec_t;

    // Displacement bytes implied by the mode field and operand selector.
    function automatic logic [1:0] disp_bytes(input logic [1:0] mode, input logic [2:0] rm);
        case (mode)
            2'b00:   return (rm == 3'b110) ? 2'd2 : 2'd0;
            2'b01:   return 2'd1;
            2'b10:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/movdec_opclass.sv
module movdec_opclass
    import movdec_pkg::*;
(
    input  logic [BYTE_W-1:0] op,
    output mov_kind_e         kind,
    output logic              dir,
    output logic              wide
);
    always_comb begin
        kind = K_BAD;
        dir  = 1'b0;
        wide = 1'b0;
        if (op[7:2] == 6'b100010) begin
            kind = K_RM;
            dir  = op[1];
            wide = op[0];
        end else if (op[7:1] == 7'b1100011) begin
            kind = K_IMM;
            wide = op[0];
        end else if (op[7:2] == 6'b100011 && op[0] == 1'b0) begin
            kind = K_SEG;
            dir  = op[1];
            wide = 1'b1;
        end
    end
endmodule

// File: rtl/movdec_fsm.sv
module movdec_fsm
    import movdec_pkg::*;
#(
    parameter bit SEG_EXT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    input  mov_kind_e         cls_kind,
    input  logic              cls_dir,
    input  logic              cls_wide,
    output mov_rec_t          rec
);
    dec_state_e state, st_n;
    mov_rec_t   rec_n;
    logic       take;
    logic [1:0] nd;
    logic       seg_bad;

    assign out_valid = (state == ST_HOLD);

    always_comb begin
        st_n     = state;
        rec_n    = rec;
        nd       = disp_bytes(in_data[7:6], in_data[2:0]);
        seg_bad  = (in_data[5:4] == 2'b11) || (!SEG_EXT && in_data[5])
                   || (rec.dir && in_data[5:3] == 3'b001);
        in_ready = (state != ST_HOLD) || out_ready;
        take     = in_valid && in_ready;
        if (state == ST_HOLD && out_ready) st_n = ST_OPC;
        if (take) begin
            if (state == ST_OPC || state == ST_HOLD) begin
                rec_n      = '0;
                rec_n.kind = cls_kind;
                rec_n.dir  = cls_dir;
                rec_n.wide = cls_wide;
                rec_n.len  = LEN_W'(1);
                if (cls_kind == K_BAD) begin
                    rec_n.illegal = 1'b1;
                    st_n          = ST_HOLD;
                end else begin
                    st_n = ST_MRM;
                end
            end else begin
                rec_n.len = rec.len + LEN_W'(1);
                case (state)
                    ST_MRM: begin
                        rec_n.mode  = in_data[7:6];
                        rec_n.rsel  = in_data[5:3];
                        rec_n.rmsel = in_data[2:0];
                        if (rec.kind == K_SEG && seg_bad) rec_n.illegal = 1'b1;
                        if (nd != 2'd0)           st_n = ST_DLO;
                        else if (rec.kind == K_IMM) st_n = ST_ILO;
                        else                      st_n = ST_HOLD;
                    end
                    ST_DLO: begin
                        if (rec.mode == 2'b01) begin
                            rec_n.disp = {{BYTE_W{in_data[BYTE_W-1]}}, in_data};
                            st_n = (rec.kind == K_IMM) ? ST_ILO : ST_HOLD;
                        end else begin
                            rec_n.disp[BYTE_W-1:0] = in_data;
                            st_n = ST_DHI;
                        end
                    end
                    ST_DHI: begin
                        rec_n.disp[WORD_W-1:BYTE_W] = in_data;
                        st_n = (rec.kind == K_IMM) ? ST_ILO : ST_HOLD;
                    end
                    ST_ILO: begin
                        rec_n.imm[BYTE_W-1:0] = in_data;
                        st_n = rec.wide ? ST_IHI : ST_HOLD;
                    end
                    ST_IHI: begin
                        rec_n.imm[WORD_W-1:BYTE_W] = in_data;
                        st_n = ST_HOLD;
                    end
                    default: st_n = ST_OPC;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OPC;
            rec   <= '0;
        end else begin
            state <= st_n;
            rec   <= rec_n;
        end
    end

    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(rec));
    assert_accept_overlap_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |-> in_ready);
    assert_unknown_len_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && rec.kind == K_BAD |-> rec.illegal && rec.len == LEN_W'(1));
    assert_direct_len_R5: assert property (@(posedge clk) disable iff (rst)
        out_valid && rec.kind != K_BAD && rec.mode == 2'b00 && rec.rmsel == 3'b110
        |-> rec.len >= LEN_W'(4));
    assert_len_bound_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> rec.len >= LEN_W'(1) && rec.len <= LEN_W'(MAX_LEN));
    assert_cs_write_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid && rec.kind == K_SEG && rec.dir && rec.rsel == 3'b001 |-> rec.illegal);
endmodule

// File: rtl/movdec.sv
module movdec
    import movdec_pkg::*;
#(
    parameter bit SEG_EXT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_illegal,
    output logic [1:0]        out_kind,
    output logic              out_dir,
    output logic              out_wide,
    output logic [1:0]        out_mode,
    output logic [2:0]        out_reg,
    output logic [2:0]        out_rm,
    output logic [WORD_W-1:0] out_disp,
    output logic [WORD_W-1:0] out_imm,
    output logic [LEN_W-1:0]  out_len
);
    mov_kind_e cls_kind;
    logic      cls_dir, cls_wide;
    mov_rec_t  rec;

    movdec_opclass u_cls (
        .op   (in_data),
        .kind (cls_kind),
        .dir  (cls_dir),
        .wide (cls_wide)
    );

    movdec_fsm #(.SEG_EXT(SEG_EXT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .cls_kind  (cls_kind),
        .cls_dir   (cls_dir),
        .cls_wide  (cls_wide),
        .rec       (rec)
    );

    assign out_illegal = rec.illegal;
    assign out_kind    = rec.kind;
    assign out_dir     = rec.dir;
    assign out_wide    = rec.wide;
    assign out_mode    = rec.mode;
    assign out_reg     = rec.rsel;
    assign out_rm      = rec.rmsel;
    assign out_disp    = rec.disp;
    assign out_imm     = rec.imm;
    assign out_len     = rec.len;
endmodule

// File: tb/sim_movdec.sv
module sim_movdec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, out_valid;
    logic        out_ready = 1'b1;
    logic        out_illegal, out_dir, out_wide;
    logic [1:0]  out_kind, out_mode;
    logic [2:0]  out_reg, out_rm, out_len;
    logic [15:0] out_disp, out_imm;

    int checks = 0;
    int errors = 0;
    logic [47:0] exp_q[$];
    int          tag_q[$];
    logic [47:0] held;

    movdec u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_illegal(out_illegal), .out_kind(out_kind), .out_dir(out_dir),
        .out_wide(out_wide), .out_mode(out_mode), .out_reg(out_reg),
        .out_rm(out_rm), .out_disp(out_disp), .out_imm(out_imm), .out_len(out_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    wire [47:0] got = {out_illegal, out_kind, out_dir, out_wide, out_mode,
                       out_reg, out_rm, out_disp, out_imm, out_len};

    function automatic logic [47:0] mk(input bit ill, input bit [1:0] k, input bit d,
        input bit w, input bit [1:0] m, input bit [2:0] r, input bit [2:0] rm,
        input bit [15:0] dp, input bit [15:0] im, input bit [2:0] ln);
        return {ill, k, d, w, m, r, rm, dp, im, ln};
    endfunction

    task automatic check(input bit ok, input string req, input logic [47:0] act,
                         input logic [47:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic put_byte(input logic [7:0] b);
        bit ok;
        in_valid = 1'b1;
        in_data  = b;
        do begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk);
            #1;
        end while (!ok);
        in_valid = 1'b0;
    endtask

    task automatic send(input int tag, input int n, input logic [7:0] b0, input logic [7:0] b1,
        input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4,
        input logic [7:0] b5, input logic [47:0] expv);
        logic [7:0] bs [6];
        bs = '{b0, b1, b2, b3, b4, b5};
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        for (int i = 0; i < n; i++) put_byte(bs[i]);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            check(in_ready, "R11 in_ready during accept", {47'd0, in_ready}, 48'd1);
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected record", got, 48'd0);
            end else begin
                logic [47:0] e;
                int t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(got == e, $sformatf("R%0d record", t), got, e);
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog expired", 48'd0, 48'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!out_valid && in_ready, "R1 reset state", {46'd0, out_valid, in_ready}, 48'd1);
        @(posedge clk); #1;

        // R2: register moves, mode 11 and mode 00 without displacement
        send(2, 2, 8'h8B, 8'hEC, 0, 0, 0, 0, mk(0, 0, 1, 1, 3, 5, 4, 16'h0, 16'h0, 2));
        send(2, 2, 8'h8A, 8'h15, 0, 0, 0, 0, mk(0, 0, 1, 0, 0, 2, 5, 16'h0, 16'h0, 2)); // R5 non-direct
        // R3: one-byte displacement, negative and positive
        send(3, 3, 8'h88, 8'h45, 8'hF0, 0, 0, 0, mk(0, 0, 0, 0, 1, 0, 5, 16'hFFF0, 16'h0, 3));
        send(3, 3, 8'h89, 8'h47, 8'h10, 0, 0, 0, mk(0, 0, 0, 1, 1, 0, 7, 16'h0010, 16'h0, 3));
        // R4: two-byte displacement
        send(4, 4, 8'h8B, 8'h86, 8'h34, 8'h12, 0, 0, mk(0, 0, 1, 1, 2, 0, 6, 16'h1234, 16'h0, 4));
        // R5: direct address
        send(5, 4, 8'h88, 8'h16, 8'h00, 8'h10, 0, 0, mk(0, 0, 0, 0, 0, 2, 6, 16'h1000, 16'h0, 4));
        // R6: immediate stores
        send(6, 6, 8'hC7, 8'h87, 8'h00, 8'h10, 8'h34, 8'h12,
             mk(0, 1, 0, 1, 2, 0, 7, 16'h1000, 16'h1234, 6));
        send(6, 5, 8'hC6, 8'h06, 8'h78, 8'h56, 8'hAB, 0,
             mk(0, 1, 0, 0, 0, 0, 6, 16'h5678, 16'h00AB, 5));
        send(6, 4, 8'hC6, 8'h40, 8'hFF, 8'h7F, 0, 0,
             mk(0, 1, 0, 0, 1, 0, 0, 16'hFFFF, 16'h007F, 4));
        // R7: segment moves
        send(7, 2, 8'h8C, 8'hCB, 0, 0, 0, 0, mk(0, 2, 0, 1, 3, 1, 3, 16'h0, 16'h0, 2));
        send(7, 2, 8'h8E, 8'hD8, 0, 0, 0, 0, mk(0, 2, 1, 1, 3, 3, 0, 16'h0, 16'h0, 2));
        send(7, 2, 8'h8C, 8'hF0, 0, 0, 0, 0, mk(1, 2, 0, 1, 3, 6, 0, 16'h0, 16'h0, 2));
        send(7, 4, 8'h8C, 8'h2E, 8'h34, 8'h12, 0, 0, mk(0, 2, 0, 1, 0, 5, 6, 16'h1234, 16'h0, 4));
        // R8: write to code segment
        send(8, 2, 8'h8E, 8'hC8, 0, 0, 0, 0, mk(1, 2, 1, 1, 3, 1, 0, 16'h0, 16'h0, 2));
        // R9: unknown opcodes, then a legal one right after
        send(9, 1, 8'h90, 0, 0, 0, 0, 0, mk(1, 3, 0, 0, 0, 0, 0, 16'h0, 16'h0, 1));
        send(9, 1, 8'hFF, 0, 0, 0, 0, 0, mk(1, 3, 0, 0, 0, 0, 0, 16'h0, 16'h0, 1));
        send(9, 2, 8'h89, 8'hD8, 0, 0, 0, 0, mk(0, 0, 0, 1, 3, 3, 0, 16'h0, 16'h0, 2));
        repeat (2) @(posedge clk); #1;

        // R10: stalled consumer with an opcode waiting
        out_ready = 1'b0;
        held = mk(0, 0, 1, 0, 3, 0, 1, 16'h0, 16'h0, 2);
        send(10, 2, 8'h8A, 8'hC1, 0, 0, 0, 0, held);
        exp_q.push_back(mk(1, 3, 0, 0, 0, 0, 0, 16'h0, 16'h0, 1));
        tag_q.push_back(10);
        in_valid = 1'b1;
        in_data  = 8'h90;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(out_valid && !in_ready && got == held, "R10 hold",
                  got, held);
        end
        @(posedge clk); #1;
        out_ready = 1'b1;
        put_byte(8'h90);
        repeat (2) @(posedge clk); #1;

        // R12: reset mid-instruction
        put_byte(8'h8B);
        put_byte(8'h86);
        put_byte(8'h34);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        check(!out_valid && in_ready, "R12 after reset", {46'd0, out_valid, in_ready}, 48'd1);
        @(posedge clk); #1;
        send(12, 2, 8'h8A, 8'h15, 0, 0, 0, 0, mk(0, 0, 1, 0, 0, 2, 5, 16'h0, 16'h0, 2));

        repeat (5) @(posedge clk);
        check(exp_q.size() == 0, "all records seen", 48'(exp_q.size()), 48'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule